// File: doc/BRIEF.md
# Critical Word Placement Predictor

This block tracks, for every slot of a set-associative cache, which word of the line was the one the processor waited for on the line's latest access. On each access, the word offset of the request is written into a 3-bit record for that set and way. When a line leaves the cache dirty, the block reads the record. It sends the recorded word to the fast memory and sends the other seven words to the slow memory, together with the record value. A later fill can then put all eight words back in their correct positions. A clean eviction writes nothing and does not change where the line's words are stored.

After reset every record holds 0. This is the same as a fixed policy that always keeps word 0 in fast memory. The records move away from that policy only as accesses are seen, and the placement in memory moves only through dirty write-backs. The eviction input and the two write-out outputs are valid/ready streams. An eviction is accepted only when both write-out registers are empty, so a dirty line always leaves as one fast beat and one slow beat. Each output beat holds its payload until it is taken. The two output ports drain on their own, and a new eviction is accepted only after both have drained. The access input is a plain strobe with no back-pressure.

Top module: `cwp_predictor`

## Requirements
- R1: After reset every record reads 0. A dirty eviction of a line that has had no access since reset sends word 0 to the fast port and index 0 on the slow port. After reset both output valids are 0 and `ev_ready` is 1.
- R2: An access (`acc_valid`=1 at a clock edge) writes `acc_word` into the record of (`acc_set`, `acc_way`). Any eviction accepted at a later edge uses that value.
- R3: An access changes only the record of the line it names. The records of every other set and way keep their values.
- R4: The cycle after a dirty eviction is accepted (`ev_valid`, `ev_ready` and `ev_dirty` all 1 at an edge), `fast_valid` and `slow_valid` are both 1. `fast_data` is word k of `ev_data`, where word i occupies bits [i*WORD_W +: WORD_W] and k is the line's record. The set and way of the eviction appear on both ports.
- R5: `slow_idx` equals k. `slow_data` holds the seven words other than k in ascending word order, with slot j at bits [j*WORD_W +: WORD_W]. Slot j carries word j when j < k and word j+1 otherwise.
- R6: An accepted eviction with `ev_dirty`=0 raises neither output valid and leaves the record unchanged.
- R7: `ev_ready` is 0 while either output valid is 1. An output whose valid is 1 and whose ready is 0 keeps its valid and payload unchanged on the next cycle.
- R8: An output beat whose valid and ready are both 1 at an edge is gone on the next cycle. The other port is not affected.
- R9: An eviction does not change the record. Two dirty evictions of the same line with no access in between carry the same index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe: the requested word started this access |
| acc_set | input | SET_W | Set of the accessed line |
| acc_way | input | WAY_W | Way of the accessed line |
| acc_word | input | IDX_W | Word offset of the request |
| ev_valid | input | 1 | Eviction offered |
| ev_ready | output | 1 | Eviction accepted at this edge if valid |
| ev_set | input | SET_W | Set of the evicted line |
| ev_way | input | WAY_W | Way of the evicted line |
| ev_dirty | input | 1 | Evicted line is modified |
| ev_data | input | WORDS*WORD_W | Line data, word i at bits [i*WORD_W +: WORD_W] |
| fast_valid | output | 1 | Fast-memory beat pending |
| fast_ready | input | 1 | Fast-memory side takes the beat |
| fast_set | output | SET_W | Set of the beat |
| fast_way | output | WAY_W | Way of the beat |
| fast_data | output | WORD_W | Predicted critical word |
| slow_valid | output | 1 | Slow-memory beat pending |
| slow_ready | input | 1 | Slow-memory side takes the beat |
| slow_set | output | SET_W | Set of the beat |
| slow_way | output | WAY_W | Way of the beat |
| slow_idx | output | IDX_W | Index of the word placed in fast memory |
| slow_data | output | (WORDS-1)*WORD_W | Remaining words, compacted in ascending order |

## Verification
An access takes effect at the edge where it is presented, so the bench offers an eviction of that line only from the next cycle on. The write-out beats appear one cycle after the edge that accepts the eviction. The bench therefore drives each eviction at a falling edge and checks both ports at the falling edge after the accepting rising edge. Hold and drain behaviour is checked one falling edge after each edge that held or took a beat. For every expected index, the bench computes the fast word and the compacted slow payload from its own model of the records.

// File: rtl/cwp_pkg.sv
package cwp_pkg;

  // Source word for a compacted slow slot, given the word kept in fast memory.
  function automatic int unsigned slot_source(input int unsigned slot,
                                              input int unsigned pick);
    return (slot < pick) ? slot : slot + 1;
  endfunction

endpackage

// File: rtl/cwp_meta_array.sv
module cwp_meta_array #(
  parameter int ENTRIES = 512,
  parameter int IDX_W   = 3,
  localparam int ADDR_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [IDX_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [IDX_W-1:0]  rd_data
);

  logic [IDX_W-1:0] rec_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) rec_q[e] <= '0;
    end else if (wr_en) begin
      rec_q[wr_addr] <= wr_data;
    end
  end

  assign rd_data = rec_q[rd_addr];

  // R2: a written record holds the written offset on the following cycle
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rec_q[$past(wr_addr)] == $past(wr_data));

endmodule

// File: rtl/cwp_line_split.sv
module cwp_line_split
  import cwp_pkg::*;
#(
  parameter int WORDS  = 8,
  parameter int WORD_W = 64,
  parameter int IDX_W  = 3
) (
  input  logic [WORDS*WORD_W-1:0]     line,
  input  logic [IDX_W-1:0]            pick,
  output logic [WORD_W-1:0]           fast_word,
  output logic [(WORDS-1)*WORD_W-1:0] slow_words
);

  assign fast_word = line[pick*WORD_W +: WORD_W];

  for (genvar s = 0; s < WORDS - 1; s++) begin : g_slot
    logic [WORD_W-1:0] lo_w, hi_w;
    assign lo_w = line[s*WORD_W +: WORD_W];
    assign hi_w = line[(s+1)*WORD_W +: WORD_W];
    always_comb begin
      if (slot_source(s, int'(pick)) == s) slow_words[s*WORD_W +: WORD_W] = lo_w;
      else                                 slow_words[s*WORD_W +: WORD_W] = hi_w;
    end
  end

endmodule

// File: rtl/cwp_out_stage.sv
module cwp_out_stage #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= load_data;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R7: a stalled beat keeps valid and payload
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R8: a taken beat is gone next cycle (loads only occur into an empty stage)
  a_r8_drain_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> !out_valid);

endmodule

// File: rtl/cwp_predictor.sv
module cwp_predictor #(
  parameter int SETS   = 64,
  parameter int WAYS   = 8,
  parameter int WORDS  = 8,
  parameter int WORD_W = 64,
  localparam int SET_W   = $clog2(SETS),
  localparam int WAY_W   = $clog2(WAYS),
  localparam int IDX_W   = $clog2(WORDS),
  localparam int LINE_W  = WORDS * WORD_W,
  localparam int SLOW_W  = (WORDS - 1) * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [SET_W-1:0]  acc_set,
  input  logic [WAY_W-1:0]  acc_way,
  input  logic [IDX_W-1:0]  acc_word,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [SET_W-1:0]  ev_set,
  input  logic [WAY_W-1:0]  ev_way,
  input  logic              ev_dirty,
  input  logic [LINE_W-1:0] ev_data,
  output logic              fast_valid,
  input  logic              fast_ready,
  output logic [SET_W-1:0]  fast_set,
  output logic [WAY_W-1:0]  fast_way,
  output logic [WORD_W-1:0] fast_data,
  output logic              slow_valid,
  input  logic              slow_ready,
  output logic [SET_W-1:0]  slow_set,
  output logic [WAY_W-1:0]  slow_way,
  output logic [IDX_W-1:0]  slow_idx,
  output logic [SLOW_W-1:0] slow_data
);

  localparam int ENTRIES = SETS * WAYS;
  localparam int ADDR_W  = SET_W + WAY_W;
  localparam int FAST_PW = ADDR_W + WORD_W;
  localparam int SLOW_PW = ADDR_W + IDX_W + SLOW_W;

  logic              ev_fire, push;
  logic [IDX_W-1:0]  pick;
  logic [WORD_W-1:0] fast_word;
  logic [SLOW_W-1:0] slow_words;
  logic [FAST_PW-1:0] fast_pl;
  logic [SLOW_PW-1:0] slow_pl;

  assign ev_ready = !fast_valid && !slow_valid;
  assign ev_fire  = ev_valid && ev_ready;
  assign push     = ev_fire && ev_dirty;

  cwp_meta_array #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_meta (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (acc_valid),
    .wr_addr ({acc_set, acc_way}),
    .wr_data (acc_word),
    .rd_addr ({ev_set, ev_way}),
    .rd_data (pick)
  );

  cwp_line_split #(.WORDS(WORDS), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_split (
    .line       (ev_data),
    .pick       (pick),
    .fast_word  (fast_word),
    .slow_words (slow_words)
  );

  cwp_out_stage #(.WIDTH(FAST_PW)) u_fast (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (push),
    .load_data ({ev_set, ev_way, fast_word}),
    .out_valid (fast_valid),
    .out_ready (fast_ready),
    .out_data  (fast_pl)
  );

  cwp_out_stage #(.WIDTH(SLOW_PW)) u_slow (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (push),
    .load_data ({ev_set, ev_way, pick, slow_words}),
    .out_valid (slow_valid),
    .out_ready (slow_ready),
    .out_data  (slow_pl)
  );

  assign {fast_set, fast_way, fast_data}           = fast_pl;
  assign {slow_set, slow_way, slow_idx, slow_data} = slow_pl;

  // R7: no eviction accepted while a beat is pending
  a_r7_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_valid || slow_valid) |-> !ev_ready);

  // R6: clean eviction raises no write-out
  a_r6_clean_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_ready && !ev_dirty) |=> (!fast_valid && !slow_valid));

  // R4: dirty eviction yields a beat on both ports carrying its address
  a_r4_dirty_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_ready && ev_dirty) |=>
      (fast_valid && slow_valid && fast_set == $past(ev_set) &&
       slow_way == $past(ev_way)));

endmodule

// File: tb/cwp_predictor_test.sv
module cwp_predictor_test;

  localparam int SETS = 4, WAYS = 2, WORDS = 8, WW = 8;
  localparam int LINES = SETS * WAYS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_valid = 0; logic [1:0] acc_set = 0; logic [0:0] acc_way = 0; logic [2:0] acc_word = 0;
  logic ev_valid = 0, ev_dirty = 0; logic ev_ready;
  logic [1:0] ev_set = 0; logic [0:0] ev_way = 0; logic [WORDS*WW-1:0] ev_data = '0;
  logic fast_valid, fast_ready = 0; logic [1:0] fast_set; logic [0:0] fast_way; logic [WW-1:0] fast_data;
  logic slow_valid, slow_ready = 0; logic [1:0] slow_set; logic [0:0] slow_way;
  logic [2:0] slow_idx; logic [(WORDS-1)*WW-1:0] slow_data;

  int checks = 0, errors = 0;
  bit done = 0;
  int model [LINES];

  always #4 clk = ~clk;

  cwp_predictor #(.SETS(SETS), .WAYS(WAYS), .WORDS(WORDS), .WORD_W(WW)) uut (.*);

  function automatic logic [WW-1:0] wbyte(int seed, int i);
    return WW'((seed * 3 + i * 17 + 1) & 255);
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(int s, int w, int word);
    @(negedge clk);
    acc_valid = 1; acc_set = 2'(s); acc_way = 1'(w); acc_word = 3'(word);
    @(negedge clk);
    acc_valid = 0;
    model[s*WAYS+w] = word;
  endtask

  // Offers one eviction; checks outputs one cycle after acceptance.
  task automatic evict(int s, int w, bit dirty, int seed, string req);
    int k;
    logic [(WORDS-1)*WW-1:0] es;
    int j;
    @(negedge clk);
    for (int i = 0; i < WORDS; i++) ev_data[i*WW +: WW] = wbyte(seed, i);
    ev_valid = 1; ev_set = 2'(s); ev_way = 1'(w); ev_dirty = dirty;
    chk(ev_ready == 1'b1, {req, " ev_ready idle"}, ev_ready, 1);
    @(negedge clk);
    ev_valid = 0;
    k = model[s*WAYS+w];
    if (dirty) begin
      j = 0;
      for (int i = 0; i < WORDS; i++)
        if (i != k) begin es[j*WW +: WW] = wbyte(seed, i); j++; end
      chk(fast_valid && fast_data == wbyte(seed, k) && fast_set == 2'(s) && fast_way == 1'(w),
          {req, " fast beat"}, {fast_valid, fast_set, fast_way, fast_data},
          {1'b1, 2'(s), 1'(w), wbyte(seed, k)});
      chk(slow_valid && slow_idx == 3'(k) && slow_data == es && slow_set == 2'(s) && slow_way == 1'(w),
          {req, " slow beat"}, {slow_idx, slow_data}, {3'(k), es});
    end else begin
      chk(!fast_valid && !slow_valid, {req, " clean silent"}, {fast_valid, slow_valid}, 0);
    end
  endtask

  task automatic drain();
    @(negedge clk);
    fast_ready = 1; slow_ready = 1;
    @(negedge clk);
    fast_ready = 0; slow_ready = 0;
  endtask

  initial begin
    for (int l = 0; l < LINES; l++) model[l] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!fast_valid && !slow_valid && ev_ready, "R1 reset outputs", {fast_valid, slow_valid, ev_ready}, 3'b001);

    // R1: every record starts at 0
    for (int l = 0; l < LINES; l++) begin evict(l / WAYS, l % WAYS, 1, l, "R1"); drain(); end

    // R2/R4/R5: sweep every line and every offset
    for (int l = 0; l < LINES; l++)
      for (int w = 0; w < WORDS; w++) begin
        access(l / WAYS, l % WAYS, (w + l) % WORDS);
        evict(l / WAYS, l % WAYS, 1, l * 8 + w, "R2 R4 R5");
        drain();
      end

    // R3: set distinct values everywhere, then read all back
    for (int l = 0; l < LINES; l++) access(l / WAYS, l % WAYS, (7 - l) & 7);
    access(0, 0, 2);
    for (int l = 0; l < LINES; l++) begin evict(l / WAYS, l % WAYS, 1, 100 + l, "R3"); drain(); end

    // R6: clean eviction writes nothing and keeps the record
    access(1, 1, 5);
    evict(1, 1, 0, 7, "R6");
    evict(1, 1, 1, 8, "R6 record kept");
    drain();

    // R9: repeat dirty eviction keeps index
    access(2, 0, 6);
    evict(2, 0, 1, 9, "R9 first");
    drain();
    evict(2, 0, 1, 10, "R9 second");

    // R7: stall for three cycles
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(fast_valid && slow_valid && !ev_ready && fast_data == wbyte(10, 6) && slow_idx == 3'd6,
          "R7 hold", {fast_valid, slow_valid, ev_ready, fast_data}, {3'b110, wbyte(10, 6)});
    end
    // R8: drain fast only
    fast_ready = 1;
    @(negedge clk);
    fast_ready = 0;
    chk(!fast_valid && slow_valid && !ev_ready, "R8 fast drained", {fast_valid, slow_valid, ev_ready}, 3'b010);
    slow_ready = 1;
    @(negedge clk);
    slow_ready = 0;
    chk(!fast_valid && !slow_valid && ev_ready, "R8 both drained", {fast_valid, slow_valid, ev_ready}, 3'b001);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule